// File: doc/BRIEF.md
# Delay-Line Critical-Path Monitor

This block estimates how far a launched edge travels through a chain of identical delay elements within one capture window. In a real part that reach follows the critical-path delay of a processor core. Here every element is modelled as one clock cycle, so the block can be simulated cycle by cycle.

A measurement starts on a launch strobe. The edge first passes a selectable pre-delay section and then a 32-tap delay line. When the capture window ends, the taps form a thermometer pattern. An encoder turns the length of its unbroken run of ones, counted from tap 0, into a 5-bit delay code. With no pre-delay and a clock ratio of one, the reference reach is 14 taps, which gives code 5'hE. Voltage-control logic further along reads this code as a calibration value.

The block holds the pre-delay select and the clock ratio from the cycle that accepts the launch until the end of that measurement. A valid pulse marks each new code. Pulling the enable low aborts any measurement and clears the outputs.

Top module: `pathdelay_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `code` is 0 and `valid` is 0.
- R2: `code` equals the number of contiguous delay-line taps reached, counted from tap 0. With `pre_sel`=0 and `ratio_sel`=0 the reach is 14, so `code` is 5'hE.
- R3: The pre-delay holds the edge back by 4×`pre_sel` elements. The reach is therefore the capture window minus 4×`pre_sel`.
- R4: The clock ratio is `ratio_sel`+1, with a range of 1 to 4. The capture window is 14×ratio cycles.
- R5: When the pre-delay is at least as long as the window, no tap is reached and `code` is 0.
- R6: A reach of 31 or more saturates `code` at 5'h1F.
- R7: `valid` is high for exactly one cycle. It rises on clock edge number 14×ratio+1 after the edge that accepted the launch.
- R8: `code` keeps its value between captures, and changes only together with `valid`.
- R9: While `en` is low, a launch is ignored and `code` and `valid` are forced to 0. Dropping `en` during a measurement aborts it, and no `valid` follows.
- R10: A launch during a measurement is ignored. Changes to `pre_sel` or `ratio_sel` after acceptance do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable |
| launch | input | 1 | Starts a measurement when the monitor is idle |
| pre_sel | input | 3 | Pre-delay select, 4 elements per step |
| ratio_sel | input | 2 | Clock ratio minus one |
| code | output | 5 | Saturated delay code |
| valid | output | 1 | One-cycle strobe marking a new code |

## Verification
The bound checker checks four rules on every cycle: `valid` lasts a single cycle, `code` holds between strobes, a low enable clears both outputs, and each strobe arrives exactly 14×ratio+1 edges after an accepted launch. The checker tracks the ratio it latched at acceptance. Only the bench scenarios can show the code values themselves. These are the reach under each pre-delay and ratio, the zero floor, the saturation at 5'h1F, and the fact that a second launch or a mid-run change of select has no effect.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
    localparam int TAPS       = 32;
    localparam int PRE_ELEMS  = 32;
    localparam int PRE_STEP   = 4;
    localparam int SEL_W      = 3;
    localparam int RATIO_W    = 2;
    localparam int CODE_W     = 5;
    localparam int REF_TAPS   = 14;
    localparam int MAX_RATIO  = 1 << RATIO_W;
    localparam int WIN_MAX    = REF_TAPS * MAX_RATIO;
    localparam int CNT_W      = $clog2(WIN_MAX + 1);
    localparam int REACH_W    = $clog2(TAPS + 1);

    typedef enum logic {ST_IDLE, ST_RUN} pdm_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] pre_sel;
        logic [CNT_W-1:0] window;
    } pdm_cfg_t;

    function automatic logic [CNT_W-1:0] window_for(input logic [RATIO_W-1:0] rsel);
        return CNT_W'(REF_TAPS * (int'(rsel) + 1));
    endfunction
endpackage

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
    import pdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             launch,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic             run,
    output logic [SEL_W-1:0] sel_q,
    output logic             capture
);
    pdm_state_e       state;
    pdm_cfg_t         cfg;
    logic [CNT_W-1:0] cnt;

    assign run     = (state == ST_RUN);
    assign sel_q   = cfg.pre_sel;
    assign capture = run && (cnt == cfg.window);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cfg   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state       <= ST_RUN;
                        cnt         <= '0;
                        cfg.pre_sel <= pre_sel;
                        cfg.window  <= window_for(ratio_sel);
                    end
                end
                default: begin
                    cnt <= cnt + 1'b1;
                    if (capture) state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/pdm_predelay.sv
module pdm_predelay #(
    parameter int ELEMS = 32,
    parameter int STEP  = 4,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             pre_out
);
    localparam int NSEL = 1 << SEL_W;

    logic [ELEMS-1:0] chain;
    logic [NSEL-1:0]  taps;

    always_ff @(posedge clk) begin
        if (rst || !run) chain <= '0;
        else             chain <= {chain[ELEMS-2:0], 1'b1};
    end

    assign taps[0] = run;
    for (genvar k = 1; k < NSEL; k++) begin : g_tap
        assign taps[k] = chain[k*STEP-1];
    end

    assign pre_out = taps[sel];
endmodule

// File: rtl/pdm_tapline.sv
module pdm_tapline #(
    parameter int TAPS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            din,
    output logic [TAPS-1:0] taps
);
    always_ff @(posedge clk) begin
        if (rst || !run) taps <= '0;
        else             taps <= {taps[TAPS-2:0], din};
    end
endmodule

// File: rtl/pdm_encoder.sv
module pdm_encoder #(
    parameter int TAPS   = 32,
    parameter int CODE_W = 5
) (
    input  logic [TAPS-1:0]   therm,
    output logic [CODE_W-1:0] code
);
    localparam int REACH_W = $clog2(TAPS + 1);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    logic [REACH_W-1:0] reach;

    // Length of the unbroken run from tap 0; ones after a gap are ignored.
    always_comb begin
        logic alive;
        alive = 1'b1;
        reach = '0;
        for (int i = 0; i < TAPS; i++) begin
            if (alive && therm[i]) reach = reach + 1'b1;
            else                   alive = 1'b0;
        end
    end

    assign code = (int'(reach) > CODE_MAX) ? CODE_W'(CODE_MAX) : CODE_W'(reach);
endmodule

// File: rtl/pathdelay_monitor.sv
module pathdelay_monitor
    import pdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               launch,
    input  logic [SEL_W-1:0]   pre_sel,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic [CODE_W-1:0]  code,
    output logic               valid
);
    logic              run, capture, pre_out;
    logic [SEL_W-1:0]  sel_q;
    logic [TAPS-1:0]   therm;
    logic [CODE_W-1:0] enc_code;

    pdm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .en(en), .launch(launch),
        .pre_sel(pre_sel), .ratio_sel(ratio_sel),
        .run(run), .sel_q(sel_q), .capture(capture)
    );

    pdm_predelay #(.ELEMS(PRE_ELEMS), .STEP(PRE_STEP), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst(rst), .run(run), .sel(sel_q), .pre_out(pre_out)
    );

    pdm_tapline #(.TAPS(TAPS)) u_line (
        .clk(clk), .rst(rst), .run(run), .din(pre_out), .taps(therm)
    );

    pdm_encoder #(.TAPS(TAPS), .CODE_W(CODE_W)) u_enc (
        .therm(therm), .code(enc_code)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            code  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) code <= enc_code;
        end
    end
endmodule

// File: rtl/pathdelay_monitor_chk.sv
module pathdelay_monitor_chk
    import pdm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               launch,
    input logic [RATIO_W-1:0] ratio_sel,
    input logic [CODE_W-1:0]  code,
    input logic               valid
);
    logic busy;
    int   cnt;
    int   win;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy <= 1'b0;
            cnt  <= 0;
            win  <= 0;
        end else if (launch && (!busy || valid)) begin
            busy <= 1'b1;
            cnt  <= 0;
            win  <= REF_TAPS * (int'(ratio_sel) + 1) + 1;
        end else if (valid) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1;
        end
    end

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !valid) |-> $stable(code));

    assert_disable_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (code == '0 && !valid));

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        valid |-> (busy && cnt == win));
endmodule

bind pathdelay_monitor pathdelay_monitor_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .launch(launch),
    .ratio_sel(ratio_sel), .code(code), .valid(valid)
);

// File: tb/tb_pathdelay_monitor.sv
module tb_pathdelay_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    // {pre_sel[2:0], ratio_sel[1:0], expected code[4:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {3'd0, 2'd0, 5'd14},   // R2 reference
        {3'd1, 2'd0, 5'd10},   // R3
        {3'd3, 2'd0, 5'd2},    // R3
        {3'd4, 2'd0, 5'd0},    // R5
        {3'd7, 2'd0, 5'd0},    // R5
        {3'd0, 2'd1, 5'd28},   // R4
        {3'd0, 2'd2, 5'd31},   // R6
        {3'd0, 2'd3, 5'd31},   // R6 full line
        {3'd7, 2'd3, 5'd28},   // R3 R4
        {3'd2, 2'd1, 5'd20},   // R3 R4
        {3'd5, 2'd2, 5'd22}    // R3 R4
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       launch = 1'b0;
    logic [2:0] pre_sel = '0;
    logic [1:0] ratio_sel = '0;
    logic [4:0] code;
    logic       valid;

    int checks = 0;
    int fails  = 0;

    pathdelay_monitor dut (
        .clk(clk), .rst(rst), .en(en), .launch(launch),
        .pre_sel(pre_sel), .ratio_sel(ratio_sel),
        .code(code), .valid(valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Called 1 time unit after a clock edge.
    task automatic measure(input logic [2:0] s, input logic [1:0] r,
                           output int lat, output logic [4:0] c);
        pre_sel = s; ratio_sel = r; launch = 1'b1;
        @(posedge clk); #1;
        launch = 1'b0;
        lat = 0;
        while (!valid && lat < 200) begin
            @(posedge clk); #1;
            lat++;
        end
        c = code;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R7 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        logic [4:0] c;
        tick(3);
        check(code == 0 && valid == 0, "R1 reset outputs", {code, valid}, 0);
        rst = 1'b0;
        tick(1);
        check(code == 0 && valid == 0, "R1 after reset", {code, valid}, 0);
        en = 1'b1;
        tick(1);

        for (int i = 0; i < NVEC; i++) begin
            int exp_lat;
            exp_lat = 14 * (int'(VEC[i][6:5]) + 1) + 1;
            measure(VEC[i][9:7], VEC[i][6:5], lat, c);
            check(c == VEC[i][4:0], "R2 R3 R4 R5 R6 code", c, VEC[i][4:0]);
            check(lat == exp_lat, "R7 latency", lat, exp_lat);
            tick(1);
            check(valid == 0, "R7 single-cycle valid", valid, 0);
        end

        // R8: code holds after capture
        measure(3'd0, 2'd0, lat, c);
        tick(6);
        check(code == 5'd14 && valid == 0, "R8 code hold", code, 14);

        // R10: second launch and new settings during a run are ignored
        pre_sel = 3'd0; ratio_sel = 2'd0; launch = 1'b1;
        tick(1);
        launch = 1'b0;
        tick(4);
        pre_sel = 3'd7; ratio_sel = 2'd3; launch = 1'b1;
        tick(1);
        launch = 1'b0;
        lat = 5;
        while (!valid && lat < 200) begin tick(1); lat++; end
        check(lat == 15, "R10 latency unaffected", lat, 15);
        check(code == 5'd14, "R10 code unaffected", code, 14);
        tick(1);

        // R9: dropping enable clears outputs
        en = 1'b0;
        tick(1);
        check(code == 0 && valid == 0, "R9 disable clears", code, 0);
        // R9: launch ignored while disabled
        launch = 1'b1;
        tick(2);
        launch = 1'b0;
        en = 1'b1;
        lat = 0;
        while (!valid && lat < 70) begin tick(1); lat++; end
        check(valid == 0 && code == 0, "R9 no launch when disabled", valid, 0);

        // R9: abort mid-measurement
        pre_sel = 3'd0; ratio_sel = 2'd0; launch = 1'b1;
        tick(1);
        launch = 1'b0;
        tick(5);
        en = 1'b0;
        tick(1);
        en = 1'b1;
        lat = 0;
        while (!valid && lat < 70) begin tick(1); lat++; end
        check(valid == 0 && code == 0, "R9 abort no valid", valid, 0);

        // R2: measurement works again after abort
        measure(3'd0, 2'd0, lat, c);
        check(c == 5'd14, "R2 after abort", c, 14);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule